// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block takes stereo PCM sample pairs on a parallel valid/ready port and sends them out as a two-channel serial stream. The stream has a bit clock, a word-select line and one data line. The block also drives a master clock for an external DAC. Every output is derived from a single oversampling clock `clk_os`, which runs at twice the master-clock rate. Each master-clock phase therefore lasts one `clk_os` cycle.

Four static configuration pins control the output. They select the sample length, the framing and the master-clock ratio, and they can release the data, word-select and master-clock pins to high impedance. A frame always has 64 bit-clock periods, 32 for each channel. One sample pair is taken per frame through a single holding register. If no pair is waiting when a frame begins, that frame carries silence and the underflow output is raised.

Top module: `aud_ser_fmt`

## Requirements
- R1: `cfg_len` selects the sample length L: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 22. The sample occupies `s_left[L-1:0]` and `s_right[L-1:0]`, is sent MSB first, and any higher input bits are ignored.
- R2: With `cfg_rj`=0 (I2S framing), the MSB of each channel is sent in the bit period after the word-select edge. The slots after the LSB up to the next channel's MSB carry 0.
- R3: With `cfg_rj`=1 (right-justified framing), the LSB of each channel sits in the last bit slot before the word-select transition. The leading unused slots carry 0.
- R4: A frame is 64 bit-clock periods long. Word-select is low for the 32 left-channel periods and high for the 32 right-channel periods.
- R5: The master clock toggles on every `clk_os` cycle. A bit-clock period holds 4 master-clock periods when `cfg_mclk384`=0 (256×fs) and 6 when `cfg_mclk384`=1 (384×fs).
- R6: Serial data and word-select change only when the bit clock falls, so they are stable at every rising bit-clock edge.
- R7: With `cfg_oe`=0, `sd_o`, `ws_o` and `mclk_o` are high impedance, while `bck_o` keeps running.
- R8: `s_ready` is high while the holding register is empty. After an accepted pair it stays low until the next frame start, so at most one pair is accepted per frame. An accepted pair is sent in the frame that follows the acceptance.
- R9: If the holding register is empty at a frame start, that whole frame sends 0 on both channels and `underflow_o` is high for that frame. The flag returns low in the next frame that has data.
- R10: While `rst_n` is low: `bck_o`=0, `ws_o`=1, `sd_o`=0, `mclk_o`=0, `s_ready`=1 and `underflow_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_os | input | 1 | Oversampling clock, twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Sample length code (16/18/20/22) |
| cfg_rj | input | 1 | 0 = I2S framing, 1 = right-justified |
| cfg_mclk384 | input | 1 | 0 = 256×fs master clock, 1 = 384×fs |
| cfg_oe | input | 1 | Output enable for data, word-select and master clock |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register can take a pair |
| s_left | input | 22 | Left sample, LSB aligned |
| s_right | input | 22 | Right sample, LSB aligned |
| mclk_o | output | 1 | Master clock, tri-stateable |
| bck_o | output | 1 | Bit clock, 64×fs |
| ws_o | output | 1 | Word select, low = left, tri-stateable |
| sd_o | output | 1 | Serial data, tri-stateable |
| underflow_o | output | 1 | High during a frame sent without data |

## Verification
The bench sends patterns whose MSB and LSB are both set, at all four lengths and in both framings. A one-slot error in the I2S delay or in the right-justified alignment therefore moves a set bit into a slot that must be zero. It offers a second pair while the first is still pending. A design that accepted twice per frame would lose a sample or shift it into the wrong frame. The bench also starves the input for one frame, which exposes a design that replays stale data or keeps the underflow flag low. It counts master-clock edges per bit clock in both ratio modes, and it disables the outputs to check that the tri-stated pins fall to the bench pull-ups while the bit clock keeps toggling.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } aud_frame_e;

  localparam int unsigned LEN_BASE = 16;
  localparam int unsigned LEN_STEP = 2;

  // sample length in bits for a 2-bit length code
  function automatic logic [5:0] len_of(input logic [1:0] code);
    return 6'(LEN_BASE) + 6'({code, 1'b0});
  endfunction

endpackage

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
  parameter int MCLK_PER_BCK_LO = 4,
  parameter int MCLK_PER_BCK_HI = 6,
  parameter int SLOT_W          = 32,
  localparam int BIT_W          = $clog2(2 * SLOT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_hi,
  output logic             mclk_q,
  output logic             bck_q,
  output logic             adv,
  output logic [BIT_W-1:0] bidx_q,
  output logic [BIT_W-1:0] bidx_n
);

  localparam int DIV_LO = 2 * MCLK_PER_BCK_LO;
  localparam int DIV_HI = 2 * MCLK_PER_BCK_HI;
  localparam int PH_W   = $clog2(DIV_HI);

  logic [PH_W-1:0] ph_q, ph_n, ph_last, ph_half;
  logic            bck_n;

  always_comb begin
    ph_last = sel_hi ? PH_W'(DIV_HI - 1) : PH_W'(DIV_LO - 1);
    ph_half = sel_hi ? PH_W'(DIV_HI / 2) : PH_W'(DIV_LO / 2);
    adv     = (ph_q >= ph_last);
    ph_n    = adv ? '0 : ph_q + 1'b1;
    bidx_n  = adv ? bidx_q + 1'b1 : bidx_q;
    bck_n   = (ph_n >= ph_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bidx_q <= '1;
      bck_q  <= 1'b0;
      mclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      bidx_q <= bidx_n;
      bck_q  <= bck_n;
      mclk_q <= ~mclk_q;
    end
  end

endmodule

// File: rtl/aud_pairbuf.sv
module aud_pairbuf #(
  parameter int SMP_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_load,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  output logic [SMP_W-1:0] word_l,
  output logic [SMP_W-1:0] word_r,
  output logic             underflow
);

  logic             full_q, full_n, take;
  logic [SMP_W-1:0] pend_l_q, pend_r_q, pend_l_n, pend_r_n;
  logic [SMP_W-1:0] word_l_n, word_r_n;
  logic             uf_n;

  assign s_ready = ~full_q;

  always_comb begin
    take     = s_valid & ~full_q;
    pend_l_n = take ? s_left  : pend_l_q;
    pend_r_n = take ? s_right : pend_r_q;
    full_n   = frame_load ? take : (full_q | take);
    word_l_n = word_l;
    word_r_n = word_r;
    uf_n     = underflow;
    if (frame_load) begin
      word_l_n = full_q ? pend_l_q : '0;
      word_r_n = full_q ? pend_r_q : '0;
      uf_n     = ~full_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      pend_l_q  <= '0;
      pend_r_q  <= '0;
      word_l    <= '0;
      word_r    <= '0;
      underflow <= 1'b0;
    end else begin
      full_q    <= full_n;
      pend_l_q  <= pend_l_n;
      pend_r_q  <= pend_r_n;
      word_l    <= word_l_n;
      word_r    <= word_r_n;
      underflow <= uf_n;
    end
  end

endmodule

// File: rtl/aud_serial.sv
module aud_serial
  import aud_fmt_pkg::*;
#(
  parameter int SMP_W  = 22,
  parameter int SLOT_W = 32,
  localparam int BIT_W = $clog2(2 * SLOT_W),
  localparam int IDX_W = $clog2(SLOT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [BIT_W-1:0] bidx_n,
  input  logic [SMP_W-1:0] word_l,
  input  logic [SMP_W-1:0] word_r,
  input  logic [1:0]       len_code,
  input  aud_frame_e       fmt,
  output logic             sd_q,
  output logic             ws_q
);

  logic [5:0]        len;
  logic [BIT_W-1:0]  pos;
  logic [IDX_W-1:0]  idx, bit_k;
  logic              chan, in_word, sd_n, ws_n;
  logic [SLOT_W-1:0] wext;

  // Slot 0 of every frame is silent in both framings, so the word register
  // reloaded on that same edge is never read there.
  always_comb begin
    len  = len_of(len_code);
    pos  = (fmt == FMT_I2S) ? bidx_n - 1'b1 : bidx_n;
    chan = pos[BIT_W-1];
    idx  = pos[IDX_W-1:0];
    if (fmt == FMT_I2S) begin
      in_word = ({1'b0, idx} < len);
      bit_k   = IDX_W'(len - 6'd1) - idx;
    end else begin
      bit_k   = IDX_W'(SLOT_W - 1) - idx;
      in_word = ({1'b0, bit_k} < len);
    end
    wext = chan ? {{(SLOT_W-SMP_W){1'b0}}, word_r}
                : {{(SLOT_W-SMP_W){1'b0}}, word_l};
    sd_n = adv ? (in_word & wext[bit_k]) : sd_q;
    ws_n = adv ? bidx_n[BIT_W-1] : ws_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= 1'b0;
      ws_q <= 1'b1;
    end else begin
      sd_q <= sd_n;
      ws_q <= ws_n;
    end
  end

endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt
  import aud_fmt_pkg::*;
#(
  parameter int SMP_W           = 22,
  parameter int SLOT_W          = 32,
  parameter int MCLK_PER_BCK_LO = 4,
  parameter int MCLK_PER_BCK_HI = 6
) (
  input  logic             clk_os,
  input  logic             rst_n,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_rj,
  input  logic             cfg_mclk384,
  input  logic             cfg_oe,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  output logic             mclk_o,
  output logic             bck_o,
  output logic             ws_o,
  output logic             sd_o,
  output logic             underflow_o
);

  localparam int BIT_W = $clog2(2 * SLOT_W);

  logic             mclk_int, bck_int, ws_int, sd_int, adv, frame_load;
  logic [BIT_W-1:0] bidx_q, bidx_n;
  logic [SMP_W-1:0] word_l, word_r;
  aud_frame_e       fmt;

  assign fmt        = cfg_rj ? FMT_RJ : FMT_I2S;
  assign frame_load = adv & (&bidx_q);

  aud_clkgen #(
    .MCLK_PER_BCK_LO(MCLK_PER_BCK_LO),
    .MCLK_PER_BCK_HI(MCLK_PER_BCK_HI),
    .SLOT_W(SLOT_W)
  ) u_clkgen (
    .clk(clk_os), .rst_n(rst_n), .sel_hi(cfg_mclk384),
    .mclk_q(mclk_int), .bck_q(bck_int), .adv(adv),
    .bidx_q(bidx_q), .bidx_n(bidx_n)
  );

  aud_pairbuf #(.SMP_W(SMP_W)) u_pairbuf (
    .clk(clk_os), .rst_n(rst_n), .frame_load(frame_load),
    .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right),
    .word_l(word_l), .word_r(word_r), .underflow(underflow_o)
  );

  aud_serial #(.SMP_W(SMP_W), .SLOT_W(SLOT_W)) u_serial (
    .clk(clk_os), .rst_n(rst_n), .adv(adv), .bidx_n(bidx_n),
    .word_l(word_l), .word_r(word_r), .len_code(cfg_len), .fmt(fmt),
    .sd_q(sd_int), .ws_q(ws_int)
  );

  assign bck_o  = bck_int;
  assign sd_o   = cfg_oe ? sd_int   : 1'bz;
  assign ws_o   = cfg_oe ? ws_int   : 1'bz;
  assign mclk_o = cfg_oe ? mclk_int : 1'bz;

endmodule

// File: rtl/aud_fmt_chk.sv
module aud_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic bck,
  input logic ws,
  input logic sd,
  input logic uf
);

  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready) else $error("second accept window"); // R8

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(bck)) else $error("data moved off falling edge"); // R6

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bck)) else $error("word select moved off falling edge"); // R6

  AST_SILENT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    uf |-> !sd) else $error("data during underflow frame"); // R9

endmodule

bind aud_ser_fmt aud_fmt_chk u_fmt_chk (
  .clk(clk_os), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .bck(bck_int), .ws(ws_int), .sd(sd_int), .uf(underflow_o)
);

// File: tb/aud_ser_fmt_tb.sv
module aud_ser_fmt_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SMP_W      = 22;

  logic             clk_os = 1'b0;
  logic             rst_n;
  logic [1:0]       cfg_len;
  logic             cfg_rj, cfg_mclk384, cfg_oe, s_valid;
  logic [SMP_W-1:0] s_left, s_right;
  wire              s_ready, bck_o, underflow_o;
  wire              mclk_w, ws_w, sd_w;

  pullup (mclk_w);
  pullup (ws_w);
  pullup (sd_w);

  int errors = 0;
  int checks = 0;

  aud_ser_fmt dut_i (
    .clk_os(clk_os), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_rj(cfg_rj),
    .cfg_mclk384(cfg_mclk384), .cfg_oe(cfg_oe), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .mclk_o(mclk_w), .bck_o(bck_o), .ws_o(ws_w), .sd_o(sd_w),
    .underflow_o(underflow_o)
  );

  always #(CLK_PERIOD/2) clk_os = ~clk_os;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- frame capture monitor ----------------
  logic [63:0] cap_sd, cap_ws;
  logic        cap_uf;
  int          cur_slot = 1000;
  int          frames_done = 0;
  logic        bck_p = 1'b0, ws_at_rise = 1'b1, sd_p = 1'b0, ws_p = 1'b1, mclk_p = 1'b0;
  logic        oe_p = 1'b0;
  int          clk_since_rise = 0, mclk_rises = 0;
  int          last_clk_per_bck = 0, last_mclk_per_bck = 0;
  int          edge_viol = 0;

  always @(negedge clk_os) begin
    if (rst_n) begin
      clk_since_rise++;
      if (mclk_w && !mclk_p) mclk_rises++;
      if (cfg_oe && oe_p && ((sd_w !== sd_p) || (ws_w !== ws_p)) && !(bck_p && !bck_o))
        edge_viol++;
      if (bck_o && !bck_p) begin
        last_clk_per_bck  = clk_since_rise;
        last_mclk_per_bck = mclk_rises;
        clk_since_rise = 0;
        mclk_rises     = 0;
        if (!ws_w && ws_at_rise) cur_slot = 0;
        else cur_slot++;
        ws_at_rise = ws_w;
        if (cur_slot < 64) begin
          cap_sd[cur_slot] = sd_w;
          cap_ws[cur_slot] = ws_w;
          if (cur_slot == 0) cap_uf = underflow_o;
          if (cur_slot == 63) frames_done++;
        end
      end
    end
    bck_p  = bck_o;
    sd_p   = sd_w;
    ws_p   = ws_w;
    mclk_p = mclk_w;
    oe_p   = cfg_oe;
  end

  // ---------------- helpers ----------------
  function automatic logic [63:0] exp_frame(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r,
                                            input int len, input logic rj);
    logic [63:0] f = '0;
    for (int s = 0; s < 64; s++) begin
      int ch, pos, k;
      logic [SMP_W-1:0] w;
      if (rj) begin
        ch = s / 32; pos = s % 32; k = 31 - pos;
      end else begin
        ch = ((s + 63) % 64) / 32; pos = (s + 63) % 32; k = len - 1 - pos;
      end
      w = ch ? r : l;
      if (k >= 0 && k < len) f[s] = w[k];
    end
    return f;
  endfunction

  function automatic logic [63:0] exp_ws();
    logic [63:0] f = '0;
    for (int s = 32; s < 64; s++) f[s] = 1'b1;
    return f;
  endfunction

  task automatic send_pair(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
    @(negedge clk_os);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk_os);
    @(negedge clk_os);
    s_valid = 1'b0;
  endtask

  task automatic run_pair(input string req, input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
    int n, len;
    len = 16 + 2 * int'(cfg_len);
    wait (cur_slot == 10);
    n = frames_done;
    send_pair(l, r);
    wait (frames_done == n + 2);
    check({req, " data"}, cap_sd, exp_frame(l, r, len, cfg_rj));
    check("R4 word select", cap_ws, exp_ws());
    check("R9 no underflow", 64'(cap_uf), 64'(0));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk_os);
    check("R10 bck", 64'(bck_o), 64'(0));
    check("R10 ws", 64'(ws_w), 64'(1));
    check("R10 sd", 64'(sd_w), 64'(0));
    check("R10 mclk", 64'(mclk_w), 64'(0));
    check("R10 ready", 64'(s_ready), 64'(1));
    check("R10 underflow", 64'(underflow_o), 64'(0));
    rst_n = 1'b1;
  endtask

  task automatic t_i2s();
    cfg_rj = 1'b0; cfg_len = 2'd0;
    run_pair("R2 R1 i2s16", 22'h3F8001, 22'h00A5C3);
    cfg_len = 2'd3;
    wait (cur_slot == 40);
    run_pair("R2 R1 i2s22", 22'h200001, 22'h2AAAAB);
    check("R5 clk per bck 256", 64'(last_clk_per_bck), 64'(8));
    check("R5 mclk per bck 256", 64'(last_mclk_per_bck), 64'(4));
  endtask

  task automatic t_rj();
    cfg_rj = 1'b1; cfg_len = 2'd1;
    wait (cur_slot == 40);
    run_pair("R3 R1 rj18", 22'h3E0001, 22'h020003);
    cfg_len = 2'd2;
    wait (cur_slot == 40);
    run_pair("R3 R1 rj20", 22'h080001, 22'h0F0F0F);
  endtask

  task automatic t_mclk384();
    cfg_mclk384 = 1'b1; cfg_rj = 1'b0; cfg_len = 2'd2;
    wait (cur_slot == 40);
    run_pair("R5 R2 i2s20 at 384", 22'h0C0003, 22'h080001);
    check("R5 clk per bck 384", 64'(last_clk_per_bck), 64'(12));
    check("R5 mclk per bck 384", 64'(last_mclk_per_bck), 64'(6));
    cfg_mclk384 = 1'b0;
  endtask

  task automatic t_underflow();
    int n;
    wait (cur_slot == 10);
    n = frames_done;
    wait (frames_done == n + 2);
    check("R9 silent frame", cap_sd, 64'(0));
    check("R9 flag set", 64'(cap_uf), 64'(1));
    run_pair("R9 recovery", 22'h3FFFFF, 22'h155555);
  endtask

  task automatic t_handshake();
    int n, acc_frame, acc_slot;
    logic [SMP_W-1:0] al = 22'h0ABCDE, ar = 22'h012345;
    logic [SMP_W-1:0] bl = 22'h3C3C3C, br = 22'h03C3C3;
    cfg_rj = 1'b0; cfg_len = 2'd3;
    wait (cur_slot == 10);
    n = frames_done;
    send_pair(al, ar);
    check("R8 ready low after accept", 64'(s_ready), 64'(0));
    @(negedge clk_os);
    s_valid = 1'b1; s_left = bl; s_right = br;
    while (!s_ready) @(negedge clk_os);
    acc_frame = frames_done; acc_slot = cur_slot;
    @(negedge clk_os);
    s_valid = 1'b0;
    check("R8 second accept waits for frame start", 64'(acc_frame), 64'(n + 1));
    check("R8 second accept slot", 64'(acc_slot), 64'(63));
    wait (frames_done == n + 2);
    check("R8 first pair frame", cap_sd, exp_frame(al, ar, 22, 1'b0));
    wait (frames_done == n + 3);
    check("R8 second pair frame", cap_sd, exp_frame(bl, br, 22, 1'b0));
  endtask

  task automatic t_disable();
    int hi_cnt = 0, bck_rises = 0;
    logic bp = bck_o;
    @(negedge clk_os);
    cfg_oe = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_os);
      if (sd_w === 1'b1 && ws_w === 1'b1 && mclk_w === 1'b1) hi_cnt++;
      if (bck_o && !bp) bck_rises++;
      bp = bck_o;
    end
    check("R7 outputs released", 64'(hi_cnt), 64'(300));
    check("R7 bck keeps running", 64'(bck_rises), 64'(37));
    cfg_oe = 1'b1;
    run_pair("R7 after enable", 22'h000F0F, 22'h0000FF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_len = 2'd0; cfg_rj = 1'b0; cfg_mclk384 = 1'b0; cfg_oe = 1'b1;
    s_valid = 1'b0; s_left = '0; s_right = '0;
    t_reset();
    t_i2s();
    t_rj();
    t_mclk384();
    t_underflow();
    t_handshake();
    t_disable();
    check("R6 data and ws edge violations", 64'(edge_viol), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule